// File: doc/BRIEF.md
# LCD Common Scan Timing Generator

This block produces the row-scan timing for a passive-matrix LCD whose commons come from this controller and whose segments come from up to four external segment-driver slaves. It selects one of 32 common outputs at a time. It also produces three signals shared with the slaves: a frame start marker, a one-clock line strobe on each row change, and an AC alternation level.

The line rate comes from a low-speed reference tick (nominally 32768 Hz) that arrives as a one-clock strobe on the system clock. The tick is divided so that the number of scanned rows times the line rate equals the selected frame rate. The divisor is an exact integer for every combination of duty (16 or 32 rows) and frame rate (64 or 128 Hz). Configuration is expected to change only while the block is disabled. While disabled, every output is low and all scan state is cleared.

Top module: `lcd_com_scan`

## Requirements
- R1: While enabled, exactly one common output is high. Scanning starts at row 0 and advances upward by one row per line period.
- R2: With duty32_i=0 (1/16 duty), only com_o[15:0] are scanned, com_o[31:16] stay low, and row 15 is followed by row 0.
- R3: With duty32_i=1 (1/32 duty), all 32 commons are scanned, and row 31 is followed by row 0.
- R4: A line period lasts a fixed number of reference ticks. That number is 32 for 1/16 duty at 64 Hz, 16 for 1/32 duty at 64 Hz, 16 for 1/16 duty at 128 Hz, and 8 for 1/32 duty at 128 Hz. fast_i=1 selects 128 Hz.
- R5: cl_o is high for exactly one clock. It rises in the clock after the tick that completes a line period, in the same clock that the new row appears on com_o.
- R6: frame_o is high exactly while row 0 is the active common, and only while enabled.
- R7: m_o is low after enable and toggles each time the scan wraps back to row 0. It does not change at any other time while enabled.
- R8: One clock after en_i is sampled low, com_o, frame_o, cl_o and m_o are all low. Ticks have no effect while disabled. One clock after en_i is sampled high, row 0 is active with frame_o high and m_o low.
- R9: After reset, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| en_i | input | 1 | Scan enable |
| tick_i | input | 1 | One-clock strobe of the low-speed reference clock |
| duty32_i | input | 1 | 1: 1/32 duty, 0: 1/16 duty |
| fast_i | input | 1 | 1: 128 Hz frame rate, 0: 64 Hz |
| com_o | output | 32 | Common select outputs, active high |
| frame_o | output | 1 | Frame start marker, high during row 0 |
| cl_o | output | 1 | Line strobe, one clock per row change |
| m_o | output | 1 | AC alternation level |

## Verification
A wrong tick count makes cl_o and the com_o step arrive early or late. This shows at the first line boundary, within at most 32 ticks. A wrong row counter or wrap point shows as a misplaced or missing common, or as an upper common in 1/16 mode, at the next line boundary. A misplaced wrap also shifts frame_o and flips m_o at the wrong time, which shows within one frame. Residual state after disabling shows one clock after en_i falls or rises, as nonzero outputs or as a scan that does not restart at row 0.

// File: rtl/lcd_scan_pkg.sv
package lcd_scan_pkg;
  // ticks per line = tick rate / (rows * frame rate)
  function automatic int unsigned line_ticks(int unsigned tick_hz, int unsigned base_hz,
                                             int unsigned num_com, logic duty32, logic fast);
    int unsigned rows;
    int unsigned rate;
    rows = duty32 ? num_com : num_com / 2;
    rate = fast ? 2 * base_hz : base_hz;
    return tick_hz / (rows * rate);
  endfunction
endpackage

// File: rtl/lcd_line_div.sv
module lcd_line_div #(
  parameter int LIM_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             tick_i,
  input  logic [LIM_W-1:0] lim_i,
  output logic             line_o
);
  logic [LIM_W-1:0] cnt_q;
  logic             last;

  assign last   = (cnt_q == lim_i - LIM_W'(1));
  assign line_o = en_i && tick_i && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!en_i)   cnt_q <= '0;
    else if (tick_i)  cnt_q <= last ? '0 : cnt_q + LIM_W'(1);
  end

  // R4
  cnt_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) && en_i |-> cnt_q < lim_i);
endmodule

// File: rtl/lcd_row_ctr.sv
module lcd_row_ctr #(
  parameter int NUM_COM = 32,
  localparam int ROW_W  = $clog2(NUM_COM)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             line_i,
  input  logic             duty32_i,
  output logic [ROW_W-1:0] row_o,
  output logic             active_o,
  output logic             cl_o,
  output logic             m_o
);
  logic [ROW_W-1:0] last_row;
  logic             wrap;

  assign last_row = duty32_i ? ROW_W'(NUM_COM - 1) : ROW_W'(NUM_COM / 2 - 1);
  assign wrap     = line_i && (row_o >= last_row);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      row_o    <= '0;
      active_o <= 1'b0;
      cl_o     <= 1'b0;
      m_o      <= 1'b0;
    end else begin
      active_o <= en_i;
      cl_o     <= line_i;
      if (!en_i) begin
        row_o <= '0;
        m_o   <= 1'b0;
      end else if (line_i) begin
        row_o <= wrap ? '0 : row_o + ROW_W'(1);
        if (wrap) m_o <= ~m_o;
      end
    end
  end

  // R1
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) && $past(line_i) && en_i && row_o != 0 |-> row_o == $past(row_o) + ROW_W'(1));
  // R1
  row_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) && !$past(line_i) |-> $stable(row_o));
endmodule

// File: rtl/lcd_com_dec.sv
module lcd_com_dec #(
  parameter int NUM_COM = 32,
  localparam int ROW_W  = $clog2(NUM_COM)
) (
  input  logic               active_i,
  input  logic               duty32_i,
  input  logic [ROW_W-1:0]   row_i,
  output logic [NUM_COM-1:0] com_o
);
  for (genvar i = 0; i < NUM_COM; i++) begin : g_com
    if (i < NUM_COM / 2) begin : g_lo
      assign com_o[i] = active_i && (row_i == ROW_W'(i));
    end else begin : g_hi
      assign com_o[i] = active_i && duty32_i && (row_i == ROW_W'(i));
    end
  end

  // R1
  always_comb one_com_chk: assert ($onehot0(com_o));
endmodule

// File: rtl/lcd_com_scan.sv
module lcd_com_scan #(
  parameter int TICK_HZ = 32768,
  parameter int BASE_HZ = 64,
  parameter int NUM_COM = 32,
  localparam int ROW_W  = $clog2(NUM_COM),
  localparam int DIV_MAX = TICK_HZ / ((NUM_COM / 2) * BASE_HZ),
  localparam int LIM_W  = $clog2(DIV_MAX + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic               tick_i,
  input  logic               duty32_i,
  input  logic               fast_i,
  output logic [NUM_COM-1:0] com_o,
  output logic               frame_o,
  output logic               cl_o,
  output logic               m_o
);
  logic [LIM_W-1:0] lim;
  logic             line;
  logic [ROW_W-1:0] row;
  logic             active;

  assign lim = LIM_W'(lcd_scan_pkg::line_ticks(TICK_HZ, BASE_HZ, NUM_COM, duty32_i, fast_i));

  lcd_line_div #(.LIM_W(LIM_W)) i_div (
    .clk_i, .rst_ni, .en_i, .tick_i, .lim_i(lim), .line_o(line)
  );

  lcd_row_ctr #(.NUM_COM(NUM_COM)) i_row (
    .clk_i, .rst_ni, .en_i, .line_i(line), .duty32_i,
    .row_o(row), .active_o(active), .cl_o, .m_o
  );

  lcd_com_dec #(.NUM_COM(NUM_COM)) i_dec (
    .active_i(active), .duty32_i, .row_i(row), .com_o
  );

  assign frame_o = active && (row == '0);

  // R8
  idle_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(en_i) |-> (com_o == '0 && !frame_o && !cl_o && !m_o));
  // R5
  cl_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cl_o |=> !cl_o);
  // R7
  m_at_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(en_i) && en_i && $changed(m_o) |-> $rose(frame_o));
  // R2
  half_duty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !duty32_i && $past(en_i) && $past(!duty32_i) |-> com_o[NUM_COM-1:NUM_COM/2] == '0);
endmodule

// File: tb/test_lcd_com_scan.sv
module test_lcd_com_scan;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        en = 0, tick = 0, duty32 = 0, fast = 0;
  logic [31:0] com;
  logic        frame, cl, m;

  int errors = 0, checks = 0;
  int e_cnt, e_row, e_m;
  bit wd_hit = 0;

  always #10 clk = ~clk;

  lcd_com_scan i_lcd_com_scan (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .tick_i(tick), .duty32_i(duty32),
    .fast_i(fast), .com_o(com), .frame_o(frame), .cl_o(cl), .m_o(m)
  );

  function automatic int exp_lim(bit d, bit f);
    case ({d, f})
      2'b00: return 32;
      2'b10: return 16;
      2'b01: return 16;
      default: return 8;
    endcase
  endfunction

  function automatic logic [31:0] exp_com(int r);
    return 32'h1 << r;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag, bit exp_cl);
    chk({tag, " com (R1 R2 R3)"}, com, exp_com(e_row));
    chk({tag, " frame (R6)"}, {31'b0, frame}, {31'b0, e_row == 0});
    chk({tag, " cl (R5 R4)"}, {31'b0, cl}, {31'b0, exp_cl});
    chk({tag, " m (R7)"}, {31'b0, m}, e_m[31:0]);
  endtask

  task automatic enable_cfg(bit d, bit f);
    @(negedge clk);
    en = 0;
    duty32 = d;
    fast = f;
    @(negedge clk);
    en = 1;
    @(negedge clk);
    e_cnt = 0; e_row = 0; e_m = 0;
    chk_all("enable R8", 0);
  endtask

  task automatic do_tick(int gap);
    bit line;
    int rows;
    rows = duty32 ? 32 : 16;
    tick = 1;
    @(negedge clk);
    tick = 0;
    line = (e_cnt == exp_lim(duty32, fast) - 1);
    if (line) begin
      e_cnt = 0;
      if (e_row == rows - 1) begin e_row = 0; e_m ^= 1; end
      else e_row++;
    end else e_cnt++;
    chk_all("tick", line);
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      if (i == 0) chk({"gap cl R5"}, {31'b0, cl}, 32'b0);
    end
  endtask

  task automatic run_frames(int nframes, bit rnd);
    int n;
    n = nframes * (duty32 ? 32 : 16) * exp_lim(duty32, fast);
    for (int k = 0; k < n; k++) do_tick(rnd ? int'($urandom_range(0, 3)) : 0);
  endtask

  initial begin
    #(20 * 200000);
    wd_hit = 1;
  end

  initial begin
    void'($urandom(32'h1cd5));
    #5;
    chk("reset com R9", com, 32'b0);
    chk("reset misc R9", {29'b0, frame, cl, m}, 32'b0);
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("post-reset R9", {frame, cl, m, com[28:0]}, 32'b0);

    // directed: each duty/rate pair, back-to-back ticks (R2 R3 R4)
    for (int c = 0; c < 4; c++) begin
      if (wd_hit) break;
      enable_cfg(c[0], c[1]);
      run_frames(2, 0);
    end

    // disable mid-scan: ticks ignored, outputs low (R8)
    enable_cfg(1, 0);
    for (int k = 0; k < 100; k++) do_tick(1);
    @(negedge clk); en = 0;
    @(negedge clk);
    chk("disabled R8", {frame, cl, m, com[28:0]}, 32'b0);
    for (int k = 0; k < 40; k++) begin
      tick = 1; @(negedge clk); tick = 0;
      chk("disabled tick R8", com, 32'b0);
      chk("disabled out R8", {29'b0, frame, cl, m}, 32'b0);
    end
    @(negedge clk); en = 1;
    @(negedge clk);
    e_cnt = 0; e_row = 0; e_m = 0;
    chk_all("re-enable R8", 0);
    run_frames(1, 1);

    // random configs with random tick gaps
    for (int c = 0; c < 6; c++) begin
      if (wd_hit) break;
      enable_cfg(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      run_frames(2, 1);
    end

    if (wd_hit) begin
      errors++; checks++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge wd_hit) begin
    errors++; checks++;
    $display("FAIL watchdog R1 actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule